// File: doc/BRIEF.md
# 32-Line Register-Mapped Pin Controller with Edge Interrupts

The block controls 32 general-purpose pins from a simple register port that completes a read or a write in one cycle, addressed by word. Software picks per line whether the line is driven, whether it drives as open drain, what value it drives, and whether its input buffer lets the pin reach the data register. Input pins are synchronised and watched for edges. Each edge sets a sticky event bit, which a mask can route to a single interrupt output.

Register bits are numbered in the reverse of line order: line n is held in bit 31−n of every register, while the pin vectors are indexed by line (index n is line n). Word addresses are 0 direction, 1 open-drain select, 2 data, 3 events, 4 interrupt mask, 5 edge select, 6 input buffer enable; address 7 is unused.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, pin_o and pin_oe_o are 0 and irq_o is 0.
- R2: Line n is controlled by register bit 31−n; pin index n of pin_i, pin_o and pin_oe_o is line n.
- R3: A direction bit of 1 makes the line an output (pin_oe_o set, pin_o equal to its data bit); 0 makes it an input with pin_oe_o clear.
- R4: With its open-drain bit set, an output line drives 0 with enable on when its data bit is 0, and turns its enable off when its data bit is 1.
- R5: Reading the data register returns the stored data bit for output lines and the synchronised pin value for input lines.
- R6: An input line whose input-buffer-enable bit is 0 reads 0 in the data register.
- R7: Event bits are sticky; writing 1 to an event bit clears it, writing 0 leaves it unchanged, writing all ones clears all events.
- R8: An edge-select bit of 1 records only falling edges on that line; 0 records rising and falling edges.
- R9: irq_o is 1 exactly when some bit is set in both the event and mask registers; a mask of 0 keeps irq_o at 0.
- R10: When an edge and a write-one-to-clear hit the same event bit in one cycle, the bit stays set.
- R11: A pin change applied before clock edge k shows in the data register after edge k+1 and in the event register after edge k+2.
- R12: Address 7 reads 0 and writes to it change no register.
- R13: Direction, open-drain, data, mask, edge-select and input-buffer-enable registers read back the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, applied at the next clock edge |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| pin_i | input | 32 | Pin input levels, index = line |
| pin_o | output | 32 | Pin output values, index = line |
| pin_oe_o | output | 32 | Pin output enables, index = line |
| irq_o | output | 1 | Combined interrupt |

## Verification
A stuck or lost event bit shows at irq_o and in the event readback two edges after the pin change that should have set it, and stays visible because events are sticky. A wrong synchroniser or previous-value stage shifts the data readback or event timing by a cycle, which the per-cycle comparison against the bench model catches at once. A reversed bit mapping or a wrong open-drain term appears on pin_o or pin_oe_o in the cycle after the offending register write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_DIR  = 3'd0,
    OFS_ODR  = 3'd1,
    OFS_DAT  = 3'd2,
    OFS_EVT  = 3'd3,
    OFS_MSK  = 3'd4,
    OFS_EDG  = 3'd5,
    OFS_IBE  = 3'd6,
    OFS_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] fall_only_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q, evt_q, rise, fall, set;

  assign rise = lvl_i & ~prev_q;
  assign fall = prev_q & ~lvl_i;
  assign set  = fall | (rise & ~fall_only_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      // set has priority over a same-cycle clear
      evt_q  <= (evt_q & ~clr_i) | set;
    end
  end

  assign evt_o = evt_q;

  // R7
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(evt_q) & ~$past(clr_i)) & ~evt_q) == '0));

  // R10
  evt_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(set) & ~evt_q) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] rdata_o,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] pin_o,
  output logic [N_LINES-1:0] pin_oe_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] dir_q, odr_q, dat_q, msk_q, edg_q, ibe_q;
  logic [N_LINES-1:0] pin_bit, sync_bit, evt, evt_clr, out_bit, oe_bit, dat_rd;

  // line n <-> register bit N_LINES-1-n
  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    assign pin_bit[N_LINES-1-n] = pin_i[n];
    assign pin_o[n]             = out_bit[N_LINES-1-n];
    assign pin_oe_o[n]          = oe_bit[N_LINES-1-n];
  end

  gpio_sync #(.W(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_bit),
    .q_o    (sync_bit)
  );

  assign evt_clr = (we_i && addr_i == OFS_EVT) ? wdata_i : '0;

  gpio_evt #(.W(N_LINES)) u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (sync_bit),
    .fall_only_i (edg_q),
    .clr_i       (evt_clr),
    .evt_o       (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      edg_q <= '0;
      ibe_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_DIR: dir_q <= wdata_i;
        OFS_ODR: odr_q <= wdata_i;
        OFS_DAT: dat_q <= wdata_i;
        OFS_MSK: msk_q <= wdata_i;
        OFS_EDG: edg_q <= wdata_i;
        OFS_IBE: ibe_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // open drain: drive low only, release on 1
  assign out_bit = dat_q & ~odr_q;
  assign oe_bit  = dir_q & ~(odr_q & dat_q);
  assign dat_rd  = (dir_q & dat_q) | (~dir_q & ibe_q & sync_bit);

  always_comb begin
    case (addr_i)
      OFS_DIR: rdata_o = dir_q;
      OFS_ODR: rdata_o = odr_q;
      OFS_DAT: rdata_o = dat_rd;
      OFS_EVT: rdata_o = evt;
      OFS_MSK: rdata_o = msk_q;
      OFS_EDG: rdata_o = edg_q;
      OFS_IBE: rdata_o = ibe_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(evt & msk_q);

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (msk_q != '0));

  // R3
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pin_oe_o) <= $countones(dir_q));

  // R12
  unused_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_NONE) |-> (rdata_o == '0));

  // R13
  msk_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MSK) |=> (msk_q == $past(wdata_i)));
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // reference model, register-bit space
  logic [31:0] m_reg [7];
  logic [31:0] m_p1 = '0, m_p2 = '0, m_p3 = '0;

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a == 3'd2) return (m_reg[0] & m_reg[2]) | (~m_reg[0] & m_reg[6] & m_p2);
    if (a == 3'd7) return '0;
    return m_reg[a];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < 7; i++) m_reg[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) m_reg[i] = '0;
      m_p1 = '0; m_p2 = '0; m_p3 = '0;
    end else begin
      logic [31:0] set, clr;
      set = (m_p3 & ~m_p2) | (~m_p3 & m_p2 & ~m_reg[5]);
      clr = (we && addr == 3'd3) ? wdata : '0;
      m_reg[3] = (m_reg[3] & ~clr) | set;
      if (we && addr != 3'd3 && addr != 3'd7) m_reg[addr] = wdata;
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = rev(pin_in);
      #2;
      check("R5 model rdata", rdata, m_read(addr));
      check("R3 model pin_o", pin_out, rev(m_reg[2] & ~m_reg[1]));
      check("R4 model pin_oe", pin_oe, rev(m_reg[0] & ~(m_reg[1] & m_reg[2])));
      check("R9 model irq", {31'd0, irq}, {31'd0, |(m_reg[3] & m_reg[4])});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1 reset read");
    check("R1 reset pin_o", pin_out, '0);
    check("R1 reset pin_oe", pin_oe, '0);
    check("R1 reset irq", {31'd0, irq}, '0);

    // R2 R3 line 0 = bit 31, line 31 = bit 0
    wr(3'd0, 32'h8000_0001);
    wr(3'd2, 32'h8000_0000);
    #1;
    check("R2 pin_o line0", pin_out, 32'h0000_0001);
    check("R3 pin_oe outputs", pin_oe, 32'h8000_0001);

    // R4 open drain
    wr(3'd1, 32'h8000_0001);
    wr(3'd2, 32'h0000_0001);
    #1;
    check("R4 od pin_oe", pin_oe, 32'h0000_0001);
    check("R4 od pin_o", pin_out, 32'h0000_0000);

    // R6 R5 input buffer gating, mixed readback
    @(negedge clk); pin_in = 32'hFFFF_FFFF;
    idle(4);
    rd(3'd2, 32'h0000_0001, "R6 ibe off");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd2, 32'h7FFF_FFFF, "R5 mixed read");

    // R8 R7 R9 events and mask
    rd(3'd3, 32'hFFFF_FFFF, "R8 rising both-edge");
    check("R9 mask zero", {31'd0, irq}, '0);
    wr(3'd3, 32'h0000_0000);
    rd(3'd3, 32'hFFFF_FFFF, "R7 write zero");
    wr(3'd3, 32'h0000_00FF);
    rd(3'd3, 32'hFFFF_FF00, "R7 partial clear");
    wr(3'd4, 32'h0000_0001);
    #1 check("R9 masked off", {31'd0, irq}, '0);
    wr(3'd4, 32'h0000_0100);
    #1 check("R9 irq on", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, '0, "R7 clear all");
    check("R9 irq off", {31'd0, irq}, '0);

    // R8 falling-only on line 0
    wr(3'd0, '0);
    wr(3'd5, 32'h8000_0000);
    @(negedge clk); pin_in = 32'hFFFF_FFFC;
    idle(3);
    rd(3'd3, 32'hC000_0000, "R8 falling");
    wr(3'd3, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'hFFFF_FFFF;
    idle(3);
    rd(3'd3, 32'h4000_0000, "R8 rise ignored line0");
    wr(3'd3, 32'hFFFF_FFFF);

    // R11 latency, line 5 = bit 26
    @(negedge clk); pin_in[5] = 1'b0;
    rd(3'd2, 32'hFFFF_FFFF, "R11 before edge");
    @(negedge clk);
    rd(3'd2, 32'hFFFF_FFFF, "R11 after 1 edge");
    @(negedge clk);
    rd(3'd2, 32'hFBFF_FFFF, "R11 data after 2 edges");
    rd(3'd3, 32'h0000_0000, "R11 evt after 2 edges");
    @(negedge clk);
    rd(3'd3, 32'h0400_0000, "R11 evt after 3 edges");
    wr(3'd3, 32'h0400_0000);
    rd(3'd3, 32'h0000_0000, "R7 single clear");

    // R10 clear collides with new edge
    @(negedge clk); pin_in[5] = 1'b1;
    @(negedge clk);
    wr(3'd3, 32'h0400_0000);
    rd(3'd3, 32'h0400_0000, "R10 set wins");
    wr(3'd3, 32'h0400_0000);
    rd(3'd3, 32'h0000_0000, "R10 later clear");

    // R12 unused address
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, '0, "R12 unused read");
    rd(3'd4, 32'h0000_0100, "R12 mask intact");
    rd(3'd0, 32'h0000_0000, "R12 dir intact");

    // R13 readback
    wr(3'd4, 32'hA5A5_0F0F);
    rd(3'd4, 32'hA5A5_0F0F, "R13 mask");
    rd(3'd1, 32'h8000_0001, "R13 odr");
    rd(3'd5, 32'h8000_0000, "R13 edge");
    rd(3'd6, 32'hFFFF_FFFF, "R13 ibe");
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, 32'h1234_5678, "R13 dir");

    idle(2);
    done = 1'b1;
    finish_run();
  end
endmodule